// File: doc/BRIEF.md
# Bitmask Dictionary Symbol Decoder

This block expands a compressed configuration stream into fixed-width symbols. It takes the compressed bits in 32-bit words through a valid/ready handshake and keeps them in a bit-level shift buffer. Codes are read from the most significant end of that buffer. Each code has a variable length and is one of three kinds. A literal code carries a full symbol. A plain code names a dictionary entry. A masked code names a dictionary entry and also flips a small group of its bits.

For a masked code, the block builds a symbol-width flip mask from the code's pattern and position fields. It does this in the same cycle as the dictionary read. The result is therefore ready after the same single register stage as for the other two kinds. Software or a loader fills the 16-entry dictionary through a simple write port before it sends the stream. The block emits at most one symbol per cycle, with a one-cycle valid pulse.

Top module: `bmdict_decomp`

## Requirements
- R1: A code whose first bit is 1 is a literal. The next 32 bits, most significant first, are output unchanged as the symbol. The code is 33 bits long.
- R2: A code that starts with the bits 0,0 is a plain code. The next 4 bits are an index, and the output is the dictionary entry at that index. The code is 6 bits long.
- R3: A code that starts with the bits 0,1 is a masked code. It holds a 4-bit index, a 3-bit position p and a 4-bit pattern, in that order. The output is the indexed entry XOR (pattern placed at symbol bits [4p+3:4p]). The code is 13 bits long.
- R4: Input words are consumed most significant bit first, with in_data[31] of the first word after reset as the first stream bit. Codes may span word boundaries.
- R5: Each complete code yields exactly one out_valid pulse, one cycle after the code is decoded. Symbols come out in stream order, at most one per cycle.
- R6: in_ready is high exactly when fewer than 33 bits are buffered, so the buffer never holds more than 64 bits.
- R7: When dict_we is high, dict_data is written to entry dict_addr. All 16 index values address an entry, and later codes use the new contents.
- R8: During and after reset, out_valid is 0, in_ready is 1 and the buffer is empty.
- R9: Zero bits that pad the end of a stream decode as plain codes for entry 0, one per 6 bits. Fewer than 6 leftover bits stay buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed word offered |
| in_ready | output | 1 | Block accepts the offered word |
| in_data | input | 32 | Compressed stream word, MSB first |
| dict_we | input | 1 | Dictionary write enable |
| dict_addr | input | 4 | Dictionary entry to write |
| dict_data | input | 32 | Dictionary entry value |
| out_valid | output | 1 | Decoded symbol valid pulse |
| out_sym | output | 32 | Decoded symbol |

## Verification
The in-line assertions check several rules on every cycle. The buffer stays within its bound. A decode produces a pulse on the next cycle and nothing else does. A literal appears unchanged. A plain code returns the entry it names. A masked code differs from its entry in at most four bits. Other properties can only be shown by the bench scenarios, which compare against an independent encoder. These are exact bit alignment across word boundaries, the mask position arithmetic, stream ordering, back-pressure stalls under dense literal traffic, a dictionary reload, and how trailing zero padding decodes.

// File: rtl/bmdict_decomp.sv
module bmdict_decomp #(
  parameter int SYM_W = 32,
  parameter int IN_W  = 32,
  parameter int IDX_W = 4,
  parameter int MSK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             dict_we,
  input  logic [IDX_W-1:0] dict_addr,
  input  logic [SYM_W-1:0] dict_data,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym
);
  localparam int POS_W    = $clog2(SYM_W / MSK_W);
  localparam int LIT_LEN  = 1 + SYM_W;
  localparam int PLN_LEN  = 2 + IDX_W;
  localparam int MSK_LEN  = 2 + IDX_W + POS_W + MSK_W;
  localparam int MAX_CODE = (LIT_LEN > MSK_LEN) ? LIT_LEN : MSK_LEN;
  localparam int BUF_W    = MAX_CODE - 1 + IN_W;
  localparam int CNT_W    = $clog2(BUF_W + 1);
  localparam int DEPTH    = 2 ** IDX_W;

  logic [BUF_W-1:0] sbuf;
  logic [CNT_W-1:0] cnt;
  logic [SYM_W-1:0] dict [DEPTH];

  wire is_lit = sbuf[BUF_W-1];
  wire is_msk = sbuf[BUF_W-2];
  wire [IDX_W-1:0] idx = sbuf[BUF_W-3 -: IDX_W];
  wire [POS_W-1:0] pos = sbuf[BUF_W-3-IDX_W -: POS_W];
  wire [MSK_W-1:0] pat = sbuf[BUF_W-3-IDX_W-POS_W -: MSK_W];

  wire [CNT_W-1:0] code_len = is_lit ? CNT_W'(LIT_LEN) :
                              is_msk ? CNT_W'(MSK_LEN) : CNT_W'(PLN_LEN);
  wire fire = (cnt >= CNT_W'(2)) && (cnt >= code_len);

  wire [SYM_W-1:0] entry = dict[idx];
  wire [SYM_W-1:0] flip  = {{(SYM_W-MSK_W){1'b0}}, pat} << (MSK_W * pos);
  wire [SYM_W-1:0] dec   = is_lit ? sbuf[BUF_W-2 -: SYM_W] :
                           is_msk ? (entry ^ flip) : entry;

  assign in_ready = cnt < CNT_W'(MAX_CODE);
  wire take = in_valid && in_ready;
  wire [CNT_W-1:0] used = fire ? code_len : '0;
  wire [CNT_W-1:0] rem  = cnt - used;
  wire [BUF_W-1:0] word_al = {in_data, {(BUF_W-IN_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbuf      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else begin
      sbuf      <= (sbuf << used) | (take ? (word_al >> rem) : '0);
      cnt       <= rem + (take ? CNT_W'(IN_W) : '0);
      out_valid <= fire;
      if (fire) out_sym <= dec;
    end
  end

  always_ff @(posedge clk)
    if (dict_we) dict[dict_addr] <= dict_data;

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BUF_W));
  a_r5_pulse_after_decode: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !out_valid);
  a_r1_literal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_lit) |=> out_sym == $past(sbuf[BUF_W-2 -: SYM_W]));
  a_r2_plain_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_lit && !is_msk && !dict_we) |=> out_sym == $past(entry));
  a_r3_mask_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_lit && is_msk && !dict_we) |=> $countones(out_sym ^ $past(entry)) <= MSK_W);
endmodule

// File: tb/bmdict_decomp_tb.sv
module bmdict_decomp_tb;
  logic clk = 0, rst_n = 0, in_valid = 0, dict_we = 0;
  logic [31:0] in_data = '0, dict_data = '0;
  logic [3:0] dict_addr = '0;
  logic out_valid, in_ready;
  logic [31:0] out_sym;

  bmdict_decomp u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dict_we(dict_we), .dict_addr(dict_addr), .dict_data(dict_data),
    .out_valid(out_valid), .out_sym(out_sym));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, stalls = 0;
  logic [31:0] dmodel [16];
  bit bits[$];
  logic [31:0] expq[$], got[$];
  int kindq[$];

  always @(negedge clk) begin
    if (out_valid) got.push_back(out_sym);
    if (in_valid && !in_ready) stalls++;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bits.push_back(v[i]);
  endtask

  function automatic logic [31:0] place(logic [3:0] pat, int p);
    return {28'b0, pat} << (4 * p);
  endfunction

  task automatic add_lit(logic [31:0] s);
    put(1, 1); put(s, 32); expq.push_back(s); kindq.push_back(1);
  endtask
  task automatic add_pln(int i);
    put(0, 2); put(i, 4); expq.push_back(dmodel[i]); kindq.push_back(2);
  endtask
  task automatic add_msk(int i, int p, logic [3:0] pat);
    put(1, 2); put(i, 4); put(p, 3); put(pat, 4);
    expq.push_back(dmodel[i] ^ place(pat, p)); kindq.push_back(3);
  endtask

  task automatic load_dict();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      dmodel[i] = $urandom; dict_we = 1; dict_addr = 4'(i); dict_data = dmodel[i];
    end
    @(negedge clk); dict_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk(out_valid == 0, "R8 out_valid", {31'b0, out_valid}, 0);
    chk(in_ready == 1, "R8 in_ready", {31'b0, in_ready}, 1);
    rst_n = 1;
  endtask

  task automatic run_phase(int n, bit directed, string tag);
    int pad, extra, nw;
    bits.delete(); expq.delete(); kindq.delete(); got.delete();
    if (directed) begin
      add_lit(32'hFFFF_FFFF); add_lit(32'h0); add_pln(0); add_pln(15);
      add_msk(0, 0, 4'hF); add_msk(15, 7, 4'hF); add_msk(5, 3, 4'h9);
      add_lit(32'hA5A5_5A5A);
    end
    for (int k = 0; k < n; k++) begin
      case ($urandom % 3)
        0: add_lit($urandom);
        1: add_pln($urandom % 16);
        default: add_msk($urandom % 16, $urandom % 8, 4'($urandom % 15 + 1));
      endcase
    end
    pad = (32 - bits.size() % 32) % 32;
    extra = pad / 6;
    put(0, pad);
    nw = bits.size() / 32;
    @(negedge clk);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 32; b++) word[31 - b] = bits[w * 32 + b];
      in_valid = 1; in_data = word;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (40) @(negedge clk);
    chk(got.size() == expq.size() + extra, {"R4/R5 symbol count ", tag},
        got.size(), expq.size() + extra);
    for (int k = 0; k < expq.size() && k < got.size(); k++)
      case (kindq[k])
        1: chk(got[k] === expq[k], {"R1 literal ", tag}, got[k], expq[k]);
        2: chk(got[k] === expq[k], {"R2/R7 plain ", tag}, got[k], expq[k]);
        default: chk(got[k] === expq[k], {"R3/R7 masked ", tag}, got[k], expq[k]);
      endcase
    for (int k = expq.size(); k < got.size(); k++)
      chk(got[k] === dmodel[0], {"R9 padding ", tag}, got[k], dmodel[0]);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    load_dict();
    do_reset();
    run_phase(150, 1, "p1");
    load_dict();
    do_reset();
    run_phase(150, 0, "p2");
    chk(stalls > 0, "R6 back-pressure seen", stalls, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule